// File: doc/BRIEF.md
# Edge-Triggered Sticky Interrupt Status Registers

This block holds two 8-bit interrupt status registers behind a small register bus. Each used bit watches one monitored signal and latches when one kind of change happens on it. The four kinds are a rise, a fall, a change in either direction, and any change of value on a 3-bit mode field. Once a bit is latched it stays set until software writes a 1 to its position. Writing a 0 leaves the bit as it is.

The block also drives a single interrupt line. This line is a registered OR of every used status bit. The monitored signals come from elsewhere: an external sync alarm, an input clock validity flag, the validity of the selected reference, and a PLL operating mode field. Software reads the registers to find out which events have happened since it last cleared them.

Reads are combinational and have no side effects. Writes to addresses other than the two status registers are ignored.

Top module: `irq_event_status`

## Requirements
- R1: Register 0x0E bit 7 (sync alarm event) sets when `ext_sync_alarm` goes from 0 to 1. A 1-to-0 transition does not set it.
- R2: Register 0x0E bit 0 (clock validity change) sets on every transition of `in3_valid`, in either direction.
- R3: Register 0x0F bit 6 (reference lost) sets when `ref_valid` goes from 1 to 0. A 0-to-1 transition does not set it.
- R4: Register 0x0F bit 7 (mode switch) sets whenever `dpll_mode` takes a value different from its value one cycle earlier. An unchanged value never sets it.
- R5: A write with `bus_wr` high to 0x0E or 0x0F clears exactly the used bits whose `bus_wdata` bit is 1. Bits written 0 keep their value. Writes to any other address change nothing.
- R6: While `rst` is high and after it is released, register 0x0E reads 0x81 and register 0x0F reads 0x00, until an event or a clear occurs. `irq` resets to 1.
- R7: `bus_rdata` is 0 whenever `bus_rd` is low or the address is neither 0x0E nor 0x0F. Reserved positions (0x0E bits 6..1 and 0x0F bits 5..0) always read 0. Reading has no effect on the status bits.
- R8: No event is recorded at the first clock edge after reset is released, whatever values the monitored inputs hold then.
- R9: When an event and a clearing write reach the same bit at the same clock edge, the bit ends up set.
- R10: `irq` equals the OR of all used status bits as they stood one clock edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data; a 1 clears the matching status bit |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read enable; gates `bus_rdata` |
| bus_rdata | output | 8 | Read data of the addressed register |
| ext_sync_alarm | input | 1 | External sync alarm monitor |
| in3_valid | input | 1 | Validity flag of a monitored input clock |
| ref_valid | input | 1 | Validity flag of the selected reference clock |
| dpll_mode | input | 3 | PLL operating mode field |
| irq | output | 1 | Registered OR of all used status bits |

## Verification
The hardest situation to reach is an event and a clearing write on the same bit at the same clock edge. Reaching it needs the monitored input and the write strobe to change at the same falling edge. The directed stimulus does exactly that for the mode bit. A long pseudo-random phase then toggles the inputs and issues writes to the status addresses and to neighbouring addresses, so the coincidence comes up many more times. A second hard case is the first edge after reset. The bench releases reset with a mode value that differs from the detector's cleared history, and checks that no mode-switch event appears.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

   typedef enum logic [1:0] {
      DET_RISE = 2'd0,
      DET_FALL = 2'd1,
      DET_ANY  = 2'd2
   } det_kind_e;

   localparam int NUM_SRC  = 4;
   localparam int SRC_SYNC = 0;
   localparam int SRC_IN3  = 1;
   localparam int SRC_MODE = 2;
   localparam int SRC_FAIL = 3;

   function automatic det_kind_e src_kind(input int idx);
      case (idx)
         SRC_SYNC: return DET_RISE;
         SRC_FAIL: return DET_FALL;
         default:  return DET_ANY;
      endcase
   endfunction

   // 0 selects the first register, 1 the second
   function automatic logic src_bank(input int idx);
      return (idx == SRC_MODE) || (idx == SRC_FAIL);
   endfunction

   function automatic logic src_rst(input int idx);
      return (idx == SRC_SYNC) || (idx == SRC_IN3);
   endfunction

   function automatic logic any_rst_set();
      logic acc;
      acc = 1'b0;
      for (int k = 0; k < NUM_SRC; k++) acc |= src_rst(k);
      return acc;
   endfunction

endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det
   import irq_stat_pkg::*;
#(
   parameter det_kind_e KIND  = DET_ANY,
   parameter int        WIDTH = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] val,
   output logic             hit
);

   logic [WIDTH-1:0] prev_q;
   logic             primed_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q   <= '0;
         primed_q <= 1'b0;
      end else begin
         prev_q   <= val;
         primed_q <= 1'b1;
      end
   end

   if (WIDTH < 1) begin : g_bad_width
      $error("irq_edge_det: WIDTH must be at least 1");
   end

   if (KIND != DET_ANY && WIDTH != 1) begin : g_bad_kind
      $error("irq_edge_det: directional detectors need WIDTH 1");
   end

   case (KIND)
      DET_RISE: begin : g_rise
         assign hit = primed_q & val[0] & ~prev_q[0];
      end
      DET_FALL: begin : g_fall
         assign hit = primed_q & ~val[0] & prev_q[0];
      end
      default: begin : g_any
         assign hit = primed_q & (val != prev_q);
      end
   endcase

endmodule

// File: rtl/irq_sticky_bit.sv
module irq_sticky_bit #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic set,
   input  logic clr,
   output logic q
);

   always_ff @(posedge clk) begin
      if (rst)      q <= RST_VAL;
      else if (set) q <= 1'b1;   // an event outranks a clear
      else if (clr) q <= 1'b0;
   end

endmodule

// File: rtl/irq_stat_readout.sv
module irq_stat_readout #(
   parameter int                ADDR_W     = 8,
   parameter int                DATA_W     = 8,
   parameter logic [ADDR_W-1:0] REG_A_ADDR = 'h0E,
   parameter logic [ADDR_W-1:0] REG_B_ADDR = 'h0F
) (
   input  logic              rd,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] reg_a,
   input  logic [DATA_W-1:0] reg_b,
   output logic [DATA_W-1:0] rdata
);

   always_comb begin
      rdata = '0;
      if (rd) begin
         if (addr == REG_A_ADDR)      rdata = reg_a;
         else if (addr == REG_B_ADDR) rdata = reg_b;
      end
   end

endmodule

// File: rtl/irq_event_status.sv
module irq_event_status
   import irq_stat_pkg::*;
#(
   parameter int                ADDR_W     = 8,
   parameter int                DATA_W     = 8,
   parameter int                MODE_W     = 3,
   parameter logic [ADDR_W-1:0] REG_A_ADDR = 'h0E,
   parameter logic [ADDR_W-1:0] REG_B_ADDR = 'h0F,
   parameter int                A_SYNC_BIT = 7,
   parameter int                A_IN3_BIT  = 0,
   parameter int                B_MODE_BIT = 7,
   parameter int                B_FAIL_BIT = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              ext_sync_alarm,
   input  logic              in3_valid,
   input  logic              ref_valid,
   input  logic [MODE_W-1:0] dpll_mode,
   output logic              irq
);

   localparam int   SRC_POS [NUM_SRC] = '{A_SYNC_BIT, A_IN3_BIT, B_MODE_BIT, B_FAIL_BIT};
   localparam logic IRQ_RST           = any_rst_set();

   // elaboration-time parameter checks
   if (MODE_W < 1) begin : g_bad_mode
      $error("irq_event_status: MODE_W must be at least 1");
   end
   if (REG_A_ADDR == REG_B_ADDR) begin : g_bad_addr
      $error("irq_event_status: register addresses must differ");
   end
   if (A_SYNC_BIT >= DATA_W || A_IN3_BIT >= DATA_W ||
       B_MODE_BIT >= DATA_W || B_FAIL_BIT >= DATA_W) begin : g_bad_pos
      $error("irq_event_status: bit position outside data width");
   end
   if (A_SYNC_BIT == A_IN3_BIT || B_MODE_BIT == B_FAIL_BIT) begin : g_bad_overlap
      $error("irq_event_status: two sources share one bit");
   end

   logic              wr_a, wr_b;
   logic [NUM_SRC-1:0] hit, clr, stat;
   logic [DATA_W-1:0] reg_a, reg_b;
   logic              wdata_unused;

   assign wr_a         = bus_wr && (bus_addr == REG_A_ADDR);
   assign wr_b         = bus_wr && (bus_addr == REG_B_ADDR);
   assign wdata_unused = ^bus_wdata;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      if (i == SRC_MODE) begin : g_field
         irq_edge_det #(
            .KIND  (src_kind(i)),
            .WIDTH (MODE_W)
         ) u_det (
            .clk (clk),
            .rst (rst),
            .val (dpll_mode),
            .hit (hit[i])
         );
      end else begin : g_flag
         logic v;
         assign v = (i == SRC_SYNC) ? ext_sync_alarm :
                    (i == SRC_IN3)  ? in3_valid      : ref_valid;
         irq_edge_det #(
            .KIND  (src_kind(i)),
            .WIDTH (1)
         ) u_det (
            .clk (clk),
            .rst (rst),
            .val (v),
            .hit (hit[i])
         );
      end

      assign clr[i] = (src_bank(i) ? wr_b : wr_a) & bus_wdata[SRC_POS[i]];

      irq_sticky_bit #(
         .RST_VAL (src_rst(i))
      ) u_bit (
         .clk (clk),
         .rst (rst),
         .set (hit[i]),
         .clr (clr[i]),
         .q   (stat[i])
      );
   end

   // place each status bit into its register; everything else reads 0
   always_comb begin
      reg_a = '0;
      reg_b = '0;
      for (int k = 0; k < NUM_SRC; k++) begin
         if (src_bank(k)) reg_b[SRC_POS[k]] = stat[k];
         else             reg_a[SRC_POS[k]] = stat[k];
      end
   end

   irq_stat_readout #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .REG_A_ADDR (REG_A_ADDR),
      .REG_B_ADDR (REG_B_ADDR)
   ) u_rd (
      .rd    (bus_rd),
      .addr  (bus_addr),
      .reg_a (reg_a),
      .reg_b (reg_b),
      .rdata (bus_rdata)
   );

   always_ff @(posedge clk) begin
      if (rst) irq <= IRQ_RST;
      else     irq <= |stat;
   end

endmodule

// File: rtl/irq_event_status_chk.sv
module irq_event_status_chk #(
   parameter int                ADDR_W     = 8,
   parameter int                DATA_W     = 8,
   parameter int                MODE_W     = 3,
   parameter logic [ADDR_W-1:0] REG_A_ADDR = 'h0E,
   parameter logic [ADDR_W-1:0] REG_B_ADDR = 'h0F,
   parameter int                A_SYNC_BIT = 7,
   parameter int                A_IN3_BIT  = 0,
   parameter int                B_MODE_BIT = 7,
   parameter int                B_FAIL_BIT = 6
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              ext_sync_alarm,
   input logic              in3_valid,
   input logic              ref_valid,
   input logic [MODE_W-1:0] dpll_mode,
   input logic              irq,
   input logic [DATA_W-1:0] reg_a,
   input logic [DATA_W-1:0] reg_b
);

   localparam logic [DATA_W-1:0] MASK_A = (DATA_W'(1) << A_SYNC_BIT) | (DATA_W'(1) << A_IN3_BIT);
   localparam logic [DATA_W-1:0] MASK_B = (DATA_W'(1) << B_MODE_BIT) | (DATA_W'(1) << B_FAIL_BIT);

   logic [1:0] warm_q;
   logic       sync_clr;

   always_ff @(posedge clk) begin
      if (rst)                  warm_q <= 2'd0;
      else if (warm_q != 2'd3)  warm_q <= warm_q + 2'd1;
   end

   assign sync_clr = bus_wr && (bus_addr == REG_A_ADDR) && bus_wdata[A_SYNC_BIT];

   AST_SYNC_RISE_SETS: assert property (@(posedge clk) disable iff (rst)
      (warm_q != 2'd0) && ext_sync_alarm && !$past(ext_sync_alarm) |=> reg_a[A_SYNC_BIT]); // R1

   AST_SYNC_FALL_QUIET: assert property (@(posedge clk) disable iff (rst)
      !ext_sync_alarm && !reg_a[A_SYNC_BIT] |=> !reg_a[A_SYNC_BIT]); // R1

   AST_IN3_EDGE_SETS: assert property (@(posedge clk) disable iff (rst)
      (warm_q != 2'd0) && (in3_valid != $past(in3_valid)) |=> reg_a[A_IN3_BIT]); // R2

   AST_REF_LOSS_SETS: assert property (@(posedge clk) disable iff (rst)
      (warm_q != 2'd0) && !ref_valid && $past(ref_valid) |=> reg_b[B_FAIL_BIT]); // R3

   AST_MODE_SWITCH_SETS: assert property (@(posedge clk) disable iff (rst)
      (warm_q != 2'd0) && (dpll_mode != $past(dpll_mode)) |=> reg_b[B_MODE_BIT]); // R4

   AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (rst)
      reg_a[A_SYNC_BIT] && !sync_clr |=> reg_a[A_SYNC_BIT]); // R5

   AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
      ((reg_a & ~MASK_A) == '0) && ((reg_b & ~MASK_B) == '0)); // R7

   AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
      !bus_rd |-> (bus_rdata == '0)); // R7

   AST_FIRST_EDGE_QUIET: assert property (@(posedge clk) disable iff (rst)
      (warm_q == 2'd0) && !bus_wr |=> (reg_a == $past(reg_a)) && (reg_b == $past(reg_b))); // R8

   AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
      (warm_q != 2'd0) && (dpll_mode != $past(dpll_mode)) && bus_wr &&
      (bus_addr == REG_B_ADDR) && bus_wdata[B_MODE_BIT] |=> reg_b[B_MODE_BIT]); // R9

   AST_IRQ_LAGS_ONE: assert property (@(posedge clk) disable iff (rst)
      (warm_q != 2'd0) |-> (irq == $past(|{reg_a, reg_b}))); // R10

endmodule

bind irq_event_status irq_event_status_chk #(
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .MODE_W     (MODE_W),
   .REG_A_ADDR (REG_A_ADDR),
   .REG_B_ADDR (REG_B_ADDR),
   .A_SYNC_BIT (A_SYNC_BIT),
   .A_IN3_BIT  (A_IN3_BIT),
   .B_MODE_BIT (B_MODE_BIT),
   .B_FAIL_BIT (B_FAIL_BIT)
) u_chk (
   .clk            (clk),
   .rst            (rst),
   .bus_addr       (bus_addr),
   .bus_wdata      (bus_wdata),
   .bus_wr         (bus_wr),
   .bus_rd         (bus_rd),
   .bus_rdata      (bus_rdata),
   .ext_sync_alarm (ext_sync_alarm),
   .in3_valid      (in3_valid),
   .ref_valid      (ref_valid),
   .dpll_mode      (dpll_mode),
   .irq            (irq),
   .reg_a          (reg_a),
   .reg_b          (reg_b)
);

// File: tb/irq_event_status_tb.sv
`timescale 1ns/1ps
module irq_event_status_tb;

   logic       clk = 1'b0;
   logic       rst;
   logic [7:0] bus_addr, bus_wdata, bus_rdata;
   logic       bus_wr, bus_rd;
   logic       ext_sync_alarm, in3_valid, ref_valid;
   logic [2:0] dpll_mode;
   logic       irq;

   int    n_checks = 0;
   int    n_fail   = 0;
   bit    done     = 0;
   string phase    = "R6";

   always #2 clk = ~clk;   // 250 MHz

   irq_event_status u_dut (
      .clk            (clk),
      .rst            (rst),
      .bus_addr       (bus_addr),
      .bus_wdata      (bus_wdata),
      .bus_wr         (bus_wr),
      .bus_rd         (bus_rd),
      .bus_rdata      (bus_rdata),
      .ext_sync_alarm (ext_sync_alarm),
      .in3_valid      (in3_valid),
      .ref_valid      (ref_valid),
      .dpll_mode      (dpll_mode),
      .irq            (irq)
   );

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s at %0t: got %02h expected %02h", req, $time, got, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [7:0] m_a, m_b;
   logic       m_irq, m_primed;
   logic       p_sync, p_in3, p_ref;
   logic [2:0] p_mode;

   function automatic logic [7:0] exp_rdata();
      if (!bus_rd)              return 8'h00;
      if (bus_addr == 8'h0E)    return m_a;
      if (bus_addr == 8'h0F)    return m_b;
      return 8'h00;
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_a = 8'h81; m_b = 8'h00; m_irq = 1'b1; m_primed = 1'b0;
      end else begin
         m_irq = ((m_a | m_b) != 8'h00);
         if (bus_wr && bus_addr == 8'h0E) begin
            if (bus_wdata[7]) m_a[7] = 1'b0;
            if (bus_wdata[0]) m_a[0] = 1'b0;
         end
         if (bus_wr && bus_addr == 8'h0F) begin
            if (bus_wdata[7]) m_b[7] = 1'b0;
            if (bus_wdata[6]) m_b[6] = 1'b0;
         end
         if (m_primed) begin
            if (ext_sync_alarm && !p_sync) m_a[7] = 1'b1;
            if (in3_valid != p_in3)        m_a[0] = 1'b1;
            if (!ref_valid && p_ref)       m_b[6] = 1'b1;
            if (dpll_mode != p_mode)       m_b[7] = 1'b1;
         end
         m_primed = 1'b1;
      end
      p_sync = ext_sync_alarm; p_in3 = in3_valid; p_ref = ref_valid; p_mode = dpll_mode;
      #1;
      if (!done) begin
         check("R10", {7'd0, irq}, {7'd0, m_irq});
         check(phase, bus_rdata, exp_rdata());
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      tick(1);
      bus_wr = 1'b0; bus_wdata = 8'h00;
   endtask

   task automatic expect_read(input string req, input logic [7:0] a, input logic [7:0] exp);
      bus_addr = a; bus_rd = 1'b1;
      #0.5;
      check(req, bus_rdata, exp);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_checks++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   // ---------------- directed and random stimulus ----------------
   initial begin
      logic [31:0] lfsr;
      rst = 1'b1; bus_addr = 8'h0E; bus_wdata = 8'h00; bus_wr = 1'b0; bus_rd = 1'b1;
      ext_sync_alarm = 1'b1; in3_valid = 1'b1; ref_valid = 1'b1; dpll_mode = 3'd5;
      tick(3);
      // R6: reset values while in reset
      expect_read("R6", 8'h0E, 8'h81);
      expect_read("R6", 8'h0F, 8'h00);
      check("R6", {7'd0, irq}, 8'h01);
      rst = 1'b0;
      tick(3);
      // R8: mode 5 differs from the cleared history, yet no switch is recorded
      phase = "R8";
      expect_read("R8", 8'h0F, 8'h00);
      expect_read("R8", 8'h0E, 8'h81);

      // R5: write-one-to-clear
      phase = "R5";
      bus_write(8'h0D, 8'hFF);
      expect_read("R5", 8'h0E, 8'h81);
      bus_write(8'h0E, 8'h00);
      expect_read("R5", 8'h0E, 8'h81);
      bus_write(8'h0E, 8'h80);
      expect_read("R5", 8'h0E, 8'h01);
      bus_write(8'h0E, 8'h01);
      expect_read("R5", 8'h0E, 8'h00);
      tick(1);
      check("R10", {7'd0, irq}, 8'h00);

      // R1: fall ignored, rise sets
      phase = "R1";
      ext_sync_alarm = 1'b0; tick(2);
      expect_read("R1", 8'h0E, 8'h00);
      ext_sync_alarm = 1'b1; tick(1);
      expect_read("R1", 8'h0E, 8'h80);
      check("R10", {7'd0, irq}, 8'h00);
      tick(1);
      check("R10", {7'd0, irq}, 8'h01);
      bus_write(8'h0E, 8'h80);

      // R2: either edge sets
      phase = "R2";
      in3_valid = 1'b0; tick(1);
      expect_read("R2", 8'h0E, 8'h01);
      bus_write(8'h0E, 8'h01);
      expect_read("R2", 8'h0E, 8'h00);
      in3_valid = 1'b1; tick(1);
      expect_read("R2", 8'h0E, 8'h01);
      bus_write(8'h0E, 8'h01);

      // R3: loss sets, recovery does not
      phase = "R3";
      ref_valid = 1'b0; tick(1);
      expect_read("R3", 8'h0F, 8'h40);
      bus_write(8'h0F, 8'h40);
      ref_valid = 1'b1; tick(1);
      expect_read("R3", 8'h0F, 8'h00);

      // R4: any change of the mode field
      phase = "R4";
      dpll_mode = 3'd6; tick(1);
      expect_read("R4", 8'h0F, 8'h80);
      bus_write(8'h0F, 8'h80);
      tick(3);
      expect_read("R4", 8'h0F, 8'h00);
      dpll_mode = 3'd1; tick(1);
      expect_read("R4", 8'h0F, 8'h80);
      bus_write(8'h0F, 8'hFF);
      expect_read("R4", 8'h0F, 8'h00);

      // R9: event and clear at the same edge
      phase = "R9";
      bus_addr = 8'h0F; bus_wdata = 8'h80; bus_wr = 1'b1; dpll_mode = 3'd2;
      tick(1);
      bus_wr = 1'b0;
      expect_read("R9", 8'h0F, 8'h80);
      bus_write(8'h0F, 8'h80);

      // R7: gating and reserved positions
      phase = "R7";
      in3_valid = 1'b0; tick(1);
      bus_write(8'h0E, 8'h7E);
      expect_read("R7", 8'h0E, 8'h01);
      bus_rd = 1'b0; #0.5;
      check("R7", bus_rdata, 8'h00);
      expect_read("R7", 8'h10, 8'h00);
      tick(1);
      expect_read("R7", 8'h0E, 8'h01);

      // pseudo-random phase against the model
      lfsr = 32'hACE1_2468;
      for (int c = 0; c < 3000; c++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         if (lfsr[3:0] == 4'd0) ext_sync_alarm = ~ext_sync_alarm;
         if (lfsr[7:4] == 4'd1) in3_valid      = ~in3_valid;
         if (lfsr[11:8] == 4'd2) ref_valid     = ~ref_valid;
         if (lfsr[15:12] == 4'd3) dpll_mode    = lfsr[18:16];
         bus_wr    = (lfsr[21:19] == 3'd0);
         bus_rd    = lfsr[22];
         bus_addr  = 8'h0D + {6'd0, lfsr[24:23]};
         bus_wdata = lfsr[31:24];
         phase     = bus_wr ? "R5" : "R7";
         tick(1);
      end
      bus_wr = 1'b0;
      tick(2);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule